// File: doc/BRIEF.md
# Byte-Multiplexed YCbCr Raster Timing Generator

This block produces the timing of a 27 MHz component digital video output, where luma and the two colour-difference samples share one 8-bit byte lane. A byte counter walks each line: 1716 clocks in the 525-line standard and 1728 clocks in the 625-line standard. A line counter walks the frame and returns to zero at a lines-per-frame value that is supplied as a register input. Its reset value in the surrounding design is 525.

The block decodes a horizontal blank, a vertical blank, a field flag and an active-window enable from the two counters. A horizontal pixel offset and a byte width place the window inside the line. A first line and a line count place it inside the frame. This lets the picture sit in the position each standard needs. Typical values are offset 139, first line 20 and 487 lines for 525-line, and offset 145, first line 23 and 576 lines for 625-line, with 1440 bytes (720 pixels) per active line. A two-bit slot code tells the downstream multiplexer which component the current byte carries. Building the timing reference code words and the data path is left to the neighbouring blocks.

Top module: `raster656_timing`

## Requirements
- R1: `h_pos` counts up by one each clock from 0 to 1715 when `std_sel` is 0, or to 1727 when `std_sel` is 1, and the clock after the last position it returns to 0.
- R2: `line_pos` advances by one on the clock where `h_pos` returns to 0, and holds otherwise. When the incremented value would reach or pass `lines_total`, it returns to 0 instead. This also covers a `lines_total` that has been lowered below the current line.
- R3: `h_blank` is 0 exactly for byte positions from S up to but not including S + `hact_bytes`. S is 2·`hact_off_px` − 8, or 0 if that is negative.
- R4: `v_blank` is 0 exactly for lines from `vact_first` up to but not including `vact_first` + `vact_lines`.
- R5: `act_en` is 1 exactly when both `h_blank` and `v_blank` are 0.
- R6: `field` is 0 on lines below `lines_total`/2 (rounded down) and 1 on lines from there to the end of the frame. It changes only at a line boundary.
- R7: `slot` is 0 (Cb) on the first active byte of each line. It then steps 1 (Y), 2 (Cr), 3 (Y) and repeats, so the active byte k places after the start has slot k mod 4.
- R8: while `rst_n` is low, including a reset asserted in the middle of a frame, `h_pos`, `line_pos`, `field` and `slot` are all 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 1 | 0 selects 1716 clocks per line, 1 selects 1728 |
| lines_total | input | 10 | Lines per frame |
| vact_first | input | 10 | First line of the active window |
| vact_lines | input | 10 | Number of active lines |
| hact_off_px | input | 10 | Horizontal window offset in pixels |
| hact_bytes | input | 11 | Active window width in byte clocks |
| h_pos | output | 11 | Current byte position in the line |
| line_pos | output | 10 | Current line in the frame |
| h_blank | output | 1 | High outside the horizontal window |
| v_blank | output | 1 | High outside the vertical window |
| field | output | 1 | Field flag, high in the second half of the frame |
| act_en | output | 1 | High inside the active window |
| slot | output | 2 | Byte component: 0 Cb, 1 Y, 2 Cr, 3 Y |

## Verification
The bench probes the window edges: the byte just before and just after each horizontal edge, and the last active byte. An off-by-one compare would show a blank or active byte one clock early or late. It checks the field flag at the midpoint line and at the frame wrap. It also lowers the line limit below the current line while the block runs; a counter that tested only for equality would run on to 1023 instead of returning to 0. Slot values are taken at the first four bytes and at the last byte of a line, where a free-running counter that did not realign would start on Y or Cr. Both standards are exercised, so a wrong clocks-per-line value moves every later line boundary.

// File: rtl/raster656_pkg.sv
`timescale 1ns/1ps
package raster656_pkg;
   typedef enum logic [1:0] {
      SLOT_CB = 2'd0,
      SLOT_YA = 2'd1,
      SLOT_CR = 2'd2,
      SLOT_YB = 2'd3
   } slot_e;

   typedef enum logic {
      STD_525 = 1'b0,
      STD_625 = 1'b1
   } std_e;
endpackage

// File: rtl/rt_byte_counter.sv
`timescale 1ns/1ps
module rt_byte_counter #(
   parameter int H_W   = 11,
   parameter int CPL_A = 1716,
   parameter int CPL_B = 1728
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           std_sel,
   output logic [H_W-1:0] h_pos,
   output logic [H_W-1:0] h_next,
   output logic           line_step
);
   localparam logic [H_W-1:0] LAST_A = H_W'(CPL_A - 1);
   localparam logic [H_W-1:0] LAST_B = H_W'(CPL_B - 1);

   logic [H_W-1:0] last_pos;

   always_comb begin
      last_pos  = (std_sel == raster656_pkg::STD_625) ? LAST_B : LAST_A;
      // >= rather than == so a standard switch mid-line cannot run past the end
      line_step = (h_pos >= last_pos);
      h_next    = line_step ? '0 : h_pos + H_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) h_pos <= '0;
      else        h_pos <= h_next;
   end
endmodule

// File: rtl/rt_line_counter.sv
`timescale 1ns/1ps
module rt_line_counter #(
   parameter int V_W        = 10,
   parameter bit INTERLACED = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           line_step,
   input  logic [V_W-1:0] lines_total,
   output logic [V_W-1:0] line_pos,
   output logic           field
);
   logic [V_W:0]   line_inc;
   logic           frame_wrap;
   logic [V_W-1:0] line_nxt;

   always_comb begin
      line_inc   = {1'b0, line_pos} + (V_W+1)'(1);
      frame_wrap = (line_inc >= {1'b0, lines_total});
      line_nxt   = frame_wrap ? '0 : line_inc[V_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         line_pos <= '0;
      else if (line_step) line_pos <= line_nxt;
   end

   generate
      if (INTERLACED) begin : g_field
         logic [V_W-1:0] mid_line;
         logic           field_q;
         assign mid_line = lines_total >> 1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         field_q <= 1'b0;
            else if (line_step) field_q <= (line_nxt >= mid_line);
         end
         assign field = field_q;
      end else begin : g_progressive
         assign field = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rt_window_decode.sv
`timescale 1ns/1ps
module rt_window_decode #(
   parameter int H_W  = 11,
   parameter int V_W  = 10,
   parameter int LEAD = 8
) (
   input  logic [H_W-1:0] h_pos,
   input  logic [V_W-1:0] line_pos,
   input  logic [H_W-2:0] hact_off_px,
   input  logic [H_W-1:0] hact_bytes,
   input  logic [V_W-1:0] vact_first,
   input  logic [V_W-1:0] vact_lines,
   output logic [H_W-1:0] h_start,
   output logic           h_blank,
   output logic           v_blank,
   output logic           act_en
);
   localparam logic [H_W:0] LEAD_W = (H_W+1)'(LEAD);

   logic [H_W:0] start_raw;
   logic [H_W:0] start_w;
   logic [H_W:0] end_w;
   logic [V_W:0] vend_w;
   logic         h_in;
   logic         v_in;

   always_comb begin
      start_raw = {1'b0, hact_off_px, 1'b0};
      start_w   = (start_raw >= LEAD_W) ? start_raw - LEAD_W : '0;
      end_w     = start_w + {1'b0, hact_bytes};
      h_in      = ({1'b0, h_pos} >= start_w) && ({1'b0, h_pos} < end_w);
      vend_w    = {1'b0, vact_first} + {1'b0, vact_lines};
      v_in      = ({1'b0, line_pos} >= {1'b0, vact_first}) && ({1'b0, line_pos} < vend_w);
      h_start   = start_w[H_W-1:0];
      h_blank   = ~h_in;
      v_blank   = ~v_in;
      act_en    = h_in & v_in;
   end
endmodule

// File: rtl/rt_slot_gen.sv
`timescale 1ns/1ps
module rt_slot_gen #(
   parameter int H_W    = 11,
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [H_W-1:0]    h_next,
   input  logic [H_W-1:0]    h_start,
   output logic [SLOT_W-1:0] slot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  slot <= '0;
      else if (h_next == h_start)  slot <= '0;
      else                         slot <= slot + SLOT_W'(1);
   end
endmodule

// File: rtl/raster656_timing.sv
`timescale 1ns/1ps
module raster656_timing #(
   parameter int H_W        = 11,
   parameter int V_W        = 10,
   parameter int CPL_A      = 1716,
   parameter int CPL_B      = 1728,
   parameter int LEAD       = 8,
   parameter bit INTERLACED = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           std_sel,
   input  logic [V_W-1:0] lines_total,
   input  logic [V_W-1:0] vact_first,
   input  logic [V_W-1:0] vact_lines,
   input  logic [H_W-2:0] hact_off_px,
   input  logic [H_W-1:0] hact_bytes,
   output logic [H_W-1:0] h_pos,
   output logic [V_W-1:0] line_pos,
   output logic           h_blank,
   output logic           v_blank,
   output logic           field,
   output logic           act_en,
   output logic [1:0]     slot
);
   localparam int SLOT_W = $bits(raster656_pkg::slot_e);

   generate
      if (CPL_A > (1 << H_W) || CPL_B > (1 << H_W)) begin : g_bad_hw
         $error("H_W too narrow for clocks per line");
      end
      if (CPL_A < 4 || CPL_B < 4) begin : g_bad_cpl
         $error("clocks per line must be at least 4");
      end
      if (LEAD < 0) begin : g_bad_lead
         $error("LEAD must not be negative");
      end
   endgenerate

   logic [H_W-1:0] h_next;
   logic [H_W-1:0] h_start;
   logic           line_step;

   rt_byte_counter #(.H_W(H_W), .CPL_A(CPL_A), .CPL_B(CPL_B)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .std_sel(std_sel),
      .h_pos(h_pos), .h_next(h_next), .line_step(line_step)
   );

   rt_line_counter #(.V_W(V_W), .INTERLACED(INTERLACED)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .line_step(line_step),
      .lines_total(lines_total), .line_pos(line_pos), .field(field)
   );

   rt_window_decode #(.H_W(H_W), .V_W(V_W), .LEAD(LEAD)) u_win (
      .h_pos(h_pos), .line_pos(line_pos),
      .hact_off_px(hact_off_px), .hact_bytes(hact_bytes),
      .vact_first(vact_first), .vact_lines(vact_lines),
      .h_start(h_start), .h_blank(h_blank), .v_blank(v_blank), .act_en(act_en)
   );

   rt_slot_gen #(.H_W(H_W), .SLOT_W(SLOT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .h_next(h_next), .h_start(h_start), .slot(slot)
   );
endmodule

// File: rtl/raster656_timing_chk.sv
`timescale 1ns/1ps
module raster656_timing_chk #(
   parameter int H_W = 11,
   parameter int V_W = 10
) (
   input logic           clk,
   input logic           rst_n,
   input logic [H_W-1:0] h_pos,
   input logic [V_W-1:0] line_pos,
   input logic           field,
   input logic           act_en,
   input logic [1:0]     slot
);
   // R1: the byte counter only steps by one unless it returns to zero
   a_r1_h_step: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && h_pos != '0) |-> h_pos == $past(h_pos) + H_W'(1));

   // R2: the line holds inside a line
   a_r2_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && h_pos != '0) |-> $stable(line_pos));

   // R2: at a line boundary the line steps by one or returns to zero
   a_r2_line_adv: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && h_pos == '0 && $past(h_pos) != '0) |->
      (line_pos == $past(line_pos) + V_W'(1) || line_pos == '0));

   // R6: the field flag moves only at a line boundary
   a_r6_field_at_line: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && h_pos != '0) |-> $stable(field));

   // R7: the first active byte carries Cb
   a_r7_slot_cb_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && act_en && !$past(act_en)) |-> slot == 2'd0);

   // R7: inside the window the slot steps by one
   a_r7_slot_seq: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && act_en && $past(act_en) && h_pos != '0) |->
      slot == $past(slot) + 2'd1);
endmodule

bind raster656_timing raster656_timing_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .line_pos(line_pos),
   .field(field), .act_en(act_en), .slot(slot)
);

// File: tb/raster656_timing_tb_top.sv
`timescale 1ns/1ps
module raster656_timing_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        std_sel = 1'b0;
   logic [9:0]  lines_total = 10'd525;
   logic [9:0]  vact_first = 10'd0;
   logic [9:0]  vact_lines = 10'd0;
   logic [9:0]  hact_off_px = 10'd0;
   logic [10:0] hact_bytes = 11'd0;
   logic [10:0] h_pos;
   logic [9:0]  line_pos;
   logic        h_blank, v_blank, field, act_en;
   logic [1:0]  slot;

   always #2.5 clk = ~clk;

   raster656_timing dut_i (
      .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .lines_total(lines_total),
      .vact_first(vact_first), .vact_lines(vact_lines), .hact_off_px(hact_off_px),
      .hact_bytes(hact_bytes), .h_pos(h_pos), .line_pos(line_pos),
      .h_blank(h_blank), .v_blank(v_blank), .field(field), .act_en(act_en), .slot(slot)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct packed { int stdv; int lpf; int first; int lines; int off; int width; } cfg_t;
   localparam cfg_t CFGS[3] = '{
      '{0,  10,  2,   5, 139, 1440},
      '{1,  12,  3,   6, 145, 1440},
      '{0, 525, 20, 487, 139, 1440}
   };

   // cfg, clocks since reset, h_pos, line_pos, h_blank, v_blank, field, act_en, slot (-1 = not checked)
   typedef struct packed { int cfg; int n; int hp; int lp; int hb; int vb; int fld; int act; int sl; } vec_t;
   localparam int NV = 24;
   localparam vec_t VECS[NV] = '{
      '{0,     0,    0, 0, 1, 1, 0, 0, -1},
      '{0,  3701,  269, 2, 1, 0, 0, 0, -1},
      '{0,  3702,  270, 2, 0, 0, 0, 1,  0},
      '{0,  3703,  271, 2, 0, 0, 0, 1,  1},
      '{0,  3704,  272, 2, 0, 0, 0, 1,  2},
      '{0,  3705,  273, 2, 0, 0, 0, 1,  3},
      '{0,  5141, 1709, 2, 0, 0, 0, 1,  3},
      '{0,  5142, 1710, 2, 1, 0, 0, 0, -1},
      '{0,  6864,    0, 4, 1, 0, 0, 0, -1},
      '{0,  8580,    0, 5, 1, 0, 1, 0, -1},
      '{0, 10796,  500, 6, 0, 0, 1, 1,  2},
      '{0, 12512,  500, 7, 0, 1, 1, 0, -1},
      '{0, 17159, 1715, 9, 1, 1, 1, 0, -1},
      '{0, 17160,    0, 0, 1, 1, 0, 0, -1},
      '{1,  1727, 1727, 0, 1, 1, 0, 0, -1},
      '{1,  1728,    0, 1, 1, 1, 0, 0, -1},
      '{1,  5466,  282, 3, 0, 0, 0, 1,  0},
      '{1,  9640, 1000, 5, 0, 0, 0, 1,  2},
      '{1, 10368,    0, 6, 1, 0, 1, 0, -1},
      '{1, 15545, 1721, 8, 0, 0, 1, 1,  3},
      '{1, 15546, 1722, 8, 1, 0, 1, 0, -1},
      '{1, 16552, 1000, 9, 0, 1, 1, 0, -1},
      '{2, 32604,    0, 19, 1, 1, 0, 0, -1},
      '{2, 34590,  270, 20, 0, 0, 0, 1,  0}
   };

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at time %0t", tag, got, exp, $time);
      end
   endtask

   task automatic apply_cfg(input int i);
      std_sel     = CFGS[i].stdv[0];
      lines_total = 10'(CFGS[i].lpf);
      vact_first  = 10'(CFGS[i].first);
      vact_lines  = 10'(CFGS[i].lines);
      hact_off_px = 10'(CFGS[i].off);
      hact_bytes  = 11'(CFGS[i].width);
   endtask

   task automatic do_reset(input int i);
      rst_n = 1'b0;
      apply_cfg(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step(input int k);
      if (k > 0) begin
         repeat (k) @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      int cur_cfg;
      int pos;
      cur_cfg = -1;
      pos = 0;

      // R8: state while reset is held
      rst_n = 1'b0;
      apply_cfg(0);
      @(posedge clk);
      @(negedge clk);
      chk("R8 h_pos in reset", int'(h_pos), 0);
      chk("R8 line_pos in reset", int'(line_pos), 0);
      chk("R8 field in reset", int'(field), 0);
      chk("R8 slot in reset", int'(slot), 0);

      // vector table walk
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].cfg != cur_cfg || VECS[i].n < pos) begin
            do_reset(VECS[i].cfg);
            cur_cfg = VECS[i].cfg;
            pos = 0;
         end
         step(VECS[i].n - pos);
         pos = VECS[i].n;
         chk("R1 byte position", int'(h_pos), VECS[i].hp);
         chk("R2 line position", int'(line_pos), VECS[i].lp);
         chk("R3 horizontal blank", int'(h_blank), VECS[i].hb);
         chk("R4 vertical blank", int'(v_blank), VECS[i].vb);
         chk("R5 active enable", int'(act_en), VECS[i].act);
         chk("R6 field flag", int'(field), VECS[i].fld);
         if (VECS[i].sl >= 0) chk("R7 byte slot", int'(slot), VECS[i].sl);
      end

      // R8: reset asserted in the middle of a frame
      do_reset(0);
      step(10796);
      chk("R8 field before midrun reset", int'(field), 1);
      rst_n = 1'b0;
      #1;
      chk("R8 h_pos after midrun reset", int'(h_pos), 0);
      chk("R8 line_pos after midrun reset", int'(line_pos), 0);
      chk("R8 field after midrun reset", int'(field), 0);
      chk("R8 slot after midrun reset", int'(slot), 0);

      // R2 and R6: lines per frame lowered below the current line
      do_reset(0);
      step(12112);
      chk("R2 line before limit change", int'(line_pos), 7);
      lines_total = 10'd6;
      step(1616);
      chk("R2 wrap after lowered limit", int'(line_pos), 0);
      chk("R1 position at wrap", int'(h_pos), 0);
      chk("R6 field after lowered limit", int'(field), 0);
      step(5 * 1716);
      chk("R2 line under new limit", int'(line_pos), 5);
      chk("R6 field past new midpoint", int'(field), 1);
      step(1716);
      chk("R2 wrap at new limit", int'(line_pos), 0);
      chk("R6 field at new frame", int'(field), 0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule